// File: doc/BRIEF.md
# Peer Doorbell Interrupt Register Block

This block is the small register window of a shared-memory peer device. Software on the local side programs an interrupt mask and reads an interrupt status register. It reads its own position among the peers from a read-only word. It rings other peers through a write-only doorbell word. A doorbell write carries a destination peer index and a vector number. The block checks both against a table that holds the number of active peers and, for each peer, the number of vectors that peer has registered. Only a doorbell that passes both checks leaves the block, as a one-cycle notify pulse that carries the peer and the vector.

Events that arrive for the local peer set the status word in legacy (pin-based) mode. The block drives a level interrupt from the status and mask words. A separate configuration port loads the peer count and the per-peer vector counts. Read responses are registered and come one cycle after the request. Register writes take effect at the clock edge that samples them.

Top module: `peer_doorbell_regs`

## Requirements
- R1: After reset the mask and status words read as zero, irq_level is low, and neither notify_valid nor rd_resp_valid is asserted.
- R2: A write to byte offset 0x00 stores all 32 bits into the mask. Reading offset 0x00 returns the stored value and does not change it.
- R3: A write to offset 0x04 stores all 32 bits into the status word. A read of offset 0x04 returns the current status and clears it to zero at the same edge.
- R4: irq_level is the OR of (status AND mask) while msi_mode is 0 and pin_present is 1. It is 0 whenever msi_mode is 1 or pin_present is 0. It follows register changes with no added cycle.
- R5: With msi_mode 0, an event_in pulse overwrites the status word with the value 1. Other status bits are not kept. With msi_mode 1, event_in leaves the status word unchanged.
- R6: When event_in (legacy mode) and a status read fall in the same cycle, the read returns the old status and the status becomes 1. A same-cycle status write loses to the event but wins over the read clear.
- R7: Write decoding ignores wr_addr bits 1:0. For example, a write to 0x06 reaches the status word and a write to 0x0F reaches the doorbell. Reads decode the exact address.
- R8: A write to offset 0x0C is a doorbell. The destination peer is wr_data[31:16], the vector is wr_data[7:0], and wr_data[15:8] is ignored. A valid doorbell raises notify_valid for exactly the one cycle after the sampling edge, with notify_peer and notify_vector.
- R9: A doorbell whose destination is greater than or equal to the configured peer count produces no notify pulse.
- R10: A doorbell whose vector is greater than or equal to the destination peer's vector count produces no notify pulse.
- R11: A read of offset 0x08 returns own_position zero-extended. Reads of 0x0C, of any unaligned address and of any other offset return zero. Writes to 0x08 change nothing.
- R12: On the configuration port, cfg_set_peers=1 loads the peer count, saturated to MAX_PEERS. cfg_set_peers=0 loads the vector count of peer cfg_peer, saturated to 256. An index of MAX_PEERS or above is ignored. Counts reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Register write request |
| wr_addr | input | 8 | Write byte address in the 256-byte window |
| wr_data | input | 32 | Write data |
| rd_valid | input | 1 | Register read request |
| rd_addr | input | 8 | Read byte address |
| rd_resp_valid | output | 1 | Read response valid, one cycle after rd_valid |
| rd_data | output | 32 | Read response data, zero when no response |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_set_peers | input | 1 | 1: load peer count, 0: load a vector count |
| cfg_peer | input | 16 | Peer index for a vector count load |
| cfg_value | input | 16 | Count value to load |
| own_position | input | 16 | Local peer position shown at offset 0x08 |
| msi_mode | input | 1 | Message-signalled mode, disables the level output |
| pin_present | input | 1 | An interrupt pin is configured |
| event_in | input | 1 | Incoming event for the local peer |
| notify_valid | output | 1 | One-cycle pulse for an accepted doorbell |
| notify_peer | output | 16 | Destination peer of the pulse |
| notify_vector | output | 8 | Vector of the pulse |
| irq_level | output | 1 | Level interrupt |

## Verification
irq_level is combinational from the registered mask and status, so it is due just after the edge that samples a register write. The bench samples it at the falling edge of that same cycle. Read data and notify pulses each pass one register, so they are checked at the falling edge after the sampling rising edge. The bench also checks that a notify pulse is gone one cycle later. A behavioural model updated on the rising edge predicts the state, and every output is compared with it at each falling edge. Directed reads and doorbells add fixed expected values for the corner cases.

// File: rtl/pdb_pkg.sv
package pdb_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int PEER_W = 16;
  localparam int VEC_W  = 8;

  localparam logic [ADDR_W-1:0] OFS_MASK = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_POS  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_BELL = 8'h0C;

  // write decoding drops the byte lane bits
  function automatic logic [ADDR_W-1:0] word_offset(input logic [ADDR_W-1:0] a);
    return a & 8'hFC;
  endfunction

  function automatic logic [15:0] clip16(input logic [15:0] v, input logic [15:0] lim);
    return (v > lim) ? lim : v;
  endfunction

  function automatic logic [PEER_W-1:0] bell_peer(input logic [DATA_W-1:0] d);
    return d[31:16];
  endfunction

  function automatic logic [VEC_W-1:0] bell_vector(input logic [DATA_W-1:0] d);
    return d[7:0];
  endfunction
endpackage

// File: rtl/pdb_peer_table.sv
module pdb_peer_table
  import pdb_pkg::*;
#(
  parameter int MAX_PEERS = 16,
  parameter int PC_W      = $clog2(MAX_PEERS + 1),
  parameter int CNT_W     = VEC_W + 1,
  parameter int IDX_W     = $clog2(MAX_PEERS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic              cfg_set_peers,
  input  logic [15:0]       cfg_peer,
  input  logic [15:0]       cfg_value,
  output logic [PC_W-1:0]   peer_count,
  input  logic [PEER_W-1:0] query_peer,
  output logic [CNT_W-1:0]  query_count
);
  localparam logic [15:0] PEER_LIM = 16'(MAX_PEERS);
  localparam logic [15:0] VEC_LIM  = 16'(1 << VEC_W);

  logic [CNT_W-1:0] cnt_q [MAX_PEERS];
  logic             count_load;

  assign count_load = cfg_valid && !cfg_set_peers;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      peer_count <= '0;
    else if (cfg_valid && cfg_set_peers)
      peer_count <= PC_W'(clip16(cfg_value, PEER_LIM));
  end

  for (genvar g = 0; g < MAX_PEERS; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cnt_q[g] <= '0;
      else if (count_load && cfg_peer == 16'(g))
        cnt_q[g] <= CNT_W'(clip16(cfg_value, VEC_LIM));
    end
  end

  always_comb begin
    if (query_peer < PEER_LIM)
      query_count = cnt_q[query_peer[IDX_W-1:0]];
    else
      query_count = '0;
  end

  AST_PEER_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(peer_count) <= MAX_PEERS); // R12
  AST_COUNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid |=> $stable(peer_count)); // R12
endmodule

// File: rtl/pdb_irq_ctrl.sv
module pdb_irq_ctrl
  import pdb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_we,
  input  logic              stat_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              stat_rd_clr,
  input  logic              event_in,
  input  logic              msi_mode,
  input  logic              pin_present,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] stat_q,
  output logic              irq_level
);
  logic event_take;
  logic pending_any;

  assign event_take  = event_in && !msi_mode;
  assign pending_any = |(stat_q & mask_q);
  assign irq_level   = pending_any && !msi_mode && pin_present;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mask_q <= '0;
    else if (mask_we)
      mask_q <= wdata;
  end

  // priority: local event, then register write, then read clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      stat_q <= '0;
    else if (event_take)
      stat_q <= 32'd1;
    else if (stat_we)
      stat_q <= wdata;
    else if (stat_rd_clr)
      stat_q <= '0;
  end

  AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_q)); // R2
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_clr && !stat_we && !event_in) |=> stat_q == '0); // R3
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_mode || !pin_present) |-> !irq_level); // R4
  AST_EVENT_WRITES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (event_in && !msi_mode) |=> stat_q == 32'd1); // R5
  AST_MSI_EVENT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (event_in && msi_mode && !stat_we && !stat_rd_clr) |=> $stable(stat_q)); // R5
endmodule

// File: rtl/pdb_doorbell_check.sv
module pdb_doorbell_check
  import pdb_pkg::*;
#(
  parameter int PC_W  = 5,
  parameter int CNT_W = VEC_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bell_hit,
  input  logic [DATA_W-1:0] bell_data,
  input  logic [PC_W-1:0]   peer_count,
  output logic [PEER_W-1:0] query_peer,
  input  logic [CNT_W-1:0]  query_count,
  output logic              notify_valid,
  output logic [PEER_W-1:0] notify_peer,
  output logic [VEC_W-1:0]  notify_vector
);
  logic [VEC_W-1:0] bell_vec;
  logic             dest_ok;
  logic             vec_ok;
  logic             bell_take;
  logic             bell_unused_mid;

  assign query_peer      = bell_peer(bell_data);
  assign bell_vec        = bell_vector(bell_data);
  assign bell_unused_mid = ^bell_data[15:8];
  assign dest_ok         = 32'(query_peer) < 32'(peer_count);
  assign vec_ok          = 32'(bell_vec) < 32'(query_count);
  assign bell_take       = bell_hit && dest_ok && vec_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      notify_valid  <= 1'b0;
      notify_peer   <= '0;
      notify_vector <= '0;
    end else begin
      notify_valid <= bell_take;
      if (bell_take) begin
        notify_peer   <= query_peer;
        notify_vector <= bell_vec;
      end
    end
  end

  AST_NOTIFY_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    notify_valid |-> $past(bell_hit)); // R8
  AST_DEST_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (bell_hit && 32'(query_peer) >= 32'(peer_count)) |=> !notify_valid); // R9
  AST_VEC_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (bell_hit && 32'(bell_vec) >= 32'(query_count)) |=> !notify_valid); // R10
endmodule

// File: rtl/peer_doorbell_regs.sv
module peer_doorbell_regs
  import pdb_pkg::*;
#(
  parameter int MAX_PEERS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid,
  input  logic [7:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic        rd_valid,
  input  logic [7:0]  rd_addr,
  output logic        rd_resp_valid,
  output logic [31:0] rd_data,
  input  logic        cfg_valid,
  input  logic        cfg_set_peers,
  input  logic [15:0] cfg_peer,
  input  logic [15:0] cfg_value,
  input  logic [15:0] own_position,
  input  logic        msi_mode,
  input  logic        pin_present,
  input  logic        event_in,
  output logic        notify_valid,
  output logic [15:0] notify_peer,
  output logic [7:0]  notify_vector,
  output logic        irq_level
);
  localparam int PC_W  = $clog2(MAX_PEERS + 1);
  localparam int CNT_W = VEC_W + 1;
  localparam int IDX_W = $clog2(MAX_PEERS);

  logic [ADDR_W-1:0] wr_off;
  logic              mask_we, stat_we, bell_hit, stat_rd_clr;
  logic [DATA_W-1:0] mask_q, stat_q, rd_value;
  logic [PC_W-1:0]   peer_count;
  logic [PEER_W-1:0] query_peer;
  logic [CNT_W-1:0]  query_count;

  assign wr_off      = word_offset(wr_addr);
  assign mask_we     = wr_valid && wr_off == OFS_MASK;
  assign stat_we     = wr_valid && wr_off == OFS_STAT;
  assign bell_hit    = wr_valid && wr_off == OFS_BELL;
  assign stat_rd_clr = rd_valid && rd_addr == OFS_STAT;

  pdb_irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .stat_we(stat_we),
    .wdata(wr_data), .stat_rd_clr(stat_rd_clr), .event_in(event_in),
    .msi_mode(msi_mode), .pin_present(pin_present), .mask_q(mask_q),
    .stat_q(stat_q), .irq_level(irq_level)
  );

  pdb_peer_table #(.MAX_PEERS(MAX_PEERS), .PC_W(PC_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_set_peers(cfg_set_peers),
    .cfg_peer(cfg_peer), .cfg_value(cfg_value), .peer_count(peer_count),
    .query_peer(query_peer), .query_count(query_count)
  );

  pdb_doorbell_check #(.PC_W(PC_W), .CNT_W(CNT_W)) u_bell (
    .clk(clk), .rst_n(rst_n), .bell_hit(bell_hit), .bell_data(wr_data),
    .peer_count(peer_count), .query_peer(query_peer), .query_count(query_count),
    .notify_valid(notify_valid), .notify_peer(notify_peer), .notify_vector(notify_vector)
  );

  always_comb begin
    case (rd_addr)
      OFS_MASK: rd_value = mask_q;
      OFS_STAT: rd_value = stat_q;
      OFS_POS:  rd_value = {16'h0000, own_position};
      default:  rd_value = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_resp_valid <= 1'b0;
      rd_data       <= '0;
    end else begin
      rd_resp_valid <= rd_valid;
      rd_data       <= rd_valid ? rd_value : '0;
    end
  end

  AST_OWN_POSITION: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_addr == OFS_POS) |=> rd_data == {16'h0000, $past(own_position)}); // R11
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_addr != OFS_MASK && rd_addr != OFS_STAT && rd_addr != OFS_POS)
      |=> rd_data == '0); // R11
  AST_RESP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> rd_resp_valid); // R3
endmodule

// File: tb/peer_doorbell_regs_bench.sv
`timescale 1ns/1ps
module peer_doorbell_regs_bench;
  localparam int MAXP = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, wr_valid, rd_valid, cfg_valid, cfg_set_peers;
  logic [7:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic [15:0] cfg_peer, cfg_value, own_position, notify_peer;
  logic        msi_mode, pin_present, event_in, rd_resp_valid, notify_valid, irq_level;
  logic [7:0]  notify_vector;

  peer_doorbell_regs #(.MAX_PEERS(MAXP)) u_peer_doorbell_regs (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_resp_valid(rd_resp_valid), .rd_data(rd_data),
    .cfg_valid(cfg_valid), .cfg_set_peers(cfg_set_peers), .cfg_peer(cfg_peer),
    .cfg_value(cfg_value), .own_position(own_position), .msi_mode(msi_mode),
    .pin_present(pin_present), .event_in(event_in), .notify_valid(notify_valid),
    .notify_peer(notify_peer), .notify_vector(notify_vector), .irq_level(irq_level)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_mask, m_stat, e_rd;
  int          m_pc;
  int          m_cnt [MAXP];
  bit          e_nv, e_rv;
  int          e_np, e_nvec;

  function automatic logic [31:0] model_read(input logic [7:0] a);
    if (a == 8'h00) return m_mask;
    if (a == 8'h04) return m_stat;
    if (a == 8'h08) return {16'h0000, own_position};
    return 32'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask = 0; m_stat = 0; m_pc = 0; e_nv = 0; e_rv = 0; e_rd = 0; e_np = 0; e_nvec = 0;
      foreach (m_cnt[i]) m_cnt[i] = 0;
    end else begin
      logic [31:0] ns;
      int w, d, v;
      ns = m_stat;
      w  = int'(wr_addr) / 4;
      e_rv = rd_valid;
      e_rd = rd_valid ? model_read(rd_addr) : 32'h0;
      if (rd_valid && rd_addr == 8'h04) ns = 0;
      e_nv = 0;
      if (wr_valid && w == 1) ns = wr_data;
      if (wr_valid && w == 0) m_mask = wr_data;
      if (wr_valid && w == 3) begin
        d = int'(wr_data[31:16]);
        v = int'(wr_data[7:0]);
        if (d < m_pc && v < m_cnt[d]) begin
          e_nv = 1; e_np = d; e_nvec = v;
        end
      end
      if (event_in && !msi_mode) ns = 1;
      m_stat = ns;
      if (cfg_valid) begin
        if (cfg_set_peers) m_pc = (int'(cfg_value) > MAXP) ? MAXP : int'(cfg_value);
        else if (int'(cfg_peer) < MAXP)
          m_cnt[cfg_peer] = (int'(cfg_value) > 256) ? 256 : int'(cfg_value);
      end
    end
  end

  // per-cycle comparison away from the rising edge
  always @(negedge clk) begin
    if (!done) begin
      bit ei;
      ei = !msi_mode && pin_present && ((m_mask & m_stat) != 0);
      chk(irq_level === ei, "R4 irq_level model", 32'(irq_level), 32'(ei));
      chk(notify_valid === e_nv, "R8 notify_valid model", 32'(notify_valid), 32'(e_nv));
      if (e_nv) begin
        chk(notify_peer == 16'(e_np), "R8 notify_peer model", 32'(notify_peer), 32'(e_np));
        chk(notify_vector == 8'(e_nvec), "R8 notify_vector model", 32'(notify_vector), 32'(e_nvec));
      end
      chk(rd_resp_valid === e_rv, "R3 rd_resp_valid model", 32'(rd_resp_valid), 32'(e_rv));
      chk(rd_data === e_rd, "R11 rd_data model", rd_data, e_rd);
    end
  end

  task automatic idle();
    wr_valid = 0; rd_valid = 0; cfg_valid = 0; event_in = 0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_valid = 1; wr_addr = a; wr_data = d; step(); idle();
  endtask

  task automatic cfg(input bit set_peers, input logic [15:0] p, input logic [15:0] v);
    cfg_valid = 1; cfg_set_peers = set_peers; cfg_peer = p; cfg_value = v; step(); idle();
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    rd_valid = 1; rd_addr = a; step(); idle();
    @(negedge clk);
    chk(rd_resp_valid && rd_data === exp, tag, rd_data, exp);
    step();
  endtask

  task automatic irq_chk(input bit exp, input string tag);
    @(negedge clk);
    chk(irq_level === exp, tag, 32'(irq_level), 32'(exp));
    step();
  endtask

  task automatic bell(input int dest, input int vec, input logic [7:0] mid, input bit fire, input string tag);
    wr(8'h0C, {16'(dest), mid, 8'(vec)});
    @(negedge clk);
    chk(notify_valid === fire, tag, 32'(notify_valid), 32'(fire));
    if (fire) begin
      chk(notify_peer == 16'(dest), tag, 32'(notify_peer), 32'(dest));
      chk(notify_vector == 8'(vec), tag, 32'(notify_vector), 32'(vec));
    end
    step();
    @(negedge clk);
    chk(notify_valid === 1'b0, "R8 pulse lasts one cycle", 32'(notify_valid), 32'h0);
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired (actual=hung expected=finished)");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0; wr_addr = 0; wr_data = 0; rd_addr = 0; cfg_set_peers = 0;
    cfg_peer = 0; cfg_value = 0; own_position = 16'h0ABC; msi_mode = 0; pin_present = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!irq_level && !notify_valid && !rd_resp_valid, "R1 outputs in reset",
        {29'h0, irq_level, notify_valid, rd_resp_valid}, 32'h0);
    step(); rst_n = 1; step();

    rd_chk(8'h00, 32'h0, "R1 mask after reset");
    rd_chk(8'h04, 32'h0, "R1 status after reset");

    // R2 mask stores all bits, read does not disturb
    wr(8'h00, 32'hA5A5_F00F);
    rd_chk(8'h00, 32'hA5A5_F00F, "R2 mask readback");
    rd_chk(8'h00, 32'hA5A5_F00F, "R2 mask kept after read");

    // R3 status write and clear on read
    wr(8'h04, 32'h8000_0001);
    rd_chk(8'h04, 32'h8000_0001, "R3 status readback");
    rd_chk(8'h04, 32'h0, "R3 status cleared by read");

    // R4 level interrupt gating
    wr(8'h00, 32'h0000_0002);
    wr(8'h04, 32'h0000_0001);
    irq_chk(1'b0, "R4 masked bit gives no irq");
    wr(8'h04, 32'h0000_0003);
    irq_chk(1'b1, "R4 unmasked bit raises irq");
    msi_mode = 1;
    irq_chk(1'b0, "R4 msi mode holds irq low");
    msi_mode = 0; pin_present = 0;
    irq_chk(1'b0, "R4 no pin holds irq low");
    pin_present = 1;
    irq_chk(1'b1, "R4 irq restored");

    // R5 event overwrites with 1; ignored in msi mode
    wr(8'h04, 32'h0000_0006);
    event_in = 1; step(); idle();
    rd_chk(8'h04, 32'h1, "R5 event writes one");
    wr(8'h04, 32'h0000_0010);
    msi_mode = 1; event_in = 1; step(); idle(); msi_mode = 0;
    rd_chk(8'h04, 32'h10, "R5 event ignored in msi mode");

    // R6 event beats read clear, write beats clear, event beats write
    wr(8'h04, 32'h0000_0022);
    event_in = 1; rd_valid = 1; rd_addr = 8'h04; step(); idle();
    @(negedge clk);
    chk(rd_data === 32'h22, "R6 read returns old status", rd_data, 32'h22);
    step();
    rd_chk(8'h04, 32'h1, "R6 event wins over read clear");
    wr_valid = 1; wr_addr = 8'h04; wr_data = 32'h55; rd_valid = 1; rd_addr = 8'h04; step(); idle();
    rd_chk(8'h04, 32'h55, "R6 write wins over read clear");
    wr_valid = 1; wr_addr = 8'h04; wr_data = 32'h77; event_in = 1; step(); idle();
    rd_chk(8'h04, 32'h1, "R6 event wins over write");

    // R7 write address low bits ignored, read exact
    wr(8'h06, 32'h0000_0033);
    rd_chk(8'h04, 32'h33, "R7 write to 0x06 reaches status");
    rd_chk(8'h05, 32'h0, "R7 unaligned read returns zero");

    // R12 configuration with saturation
    cfg(1'b1, 16'd0, 16'd40);
    cfg(1'b0, 16'd15, 16'd1);
    bell(15, 0, 8'h00, 1'b1, "R12 peer count saturated to table size");
    bell(16, 0, 8'h00, 1'b0, "R12 R9 peer beyond saturated count");
    cfg(1'b0, 16'd40, 16'd5);
    bell(15, 1, 8'h00, 1'b0, "R12 out-of-table index ignored");
    cfg(1'b1, 16'd0, 16'd3);
    cfg(1'b0, 16'd0, 16'd2);
    cfg(1'b0, 16'd1, 16'd0);
    cfg(1'b0, 16'd2, 16'd300);

    // R8 decode and pulse
    bell(0, 1, 8'hFF, 1'b1, "R8 doorbell peer0 vector1, middle bits ignored");
    wr(8'h0F, {16'd2, 8'h00, 8'd7});
    @(negedge clk);
    chk(notify_valid && notify_peer == 16'd2, "R7 write to 0x0F is doorbell",
        32'(notify_peer), 32'd2);
    step();

    // R9 destination checks
    bell(3, 0, 8'h00, 1'b0, "R9 destination equal to peer count");
    bell(16'hFFFF, 0, 8'h00, 1'b0, "R9 largest destination");

    // R10 vector checks
    bell(0, 2, 8'h00, 1'b0, "R10 vector equal to count");
    bell(1, 0, 8'h00, 1'b0, "R10 peer with no vectors");
    bell(2, 255, 8'h00, 1'b1, "R10 R12 vector 255 with count saturated to 256");

    // R11 own position and unmapped reads, write to 0x08 ignored
    wr(8'h00, 32'h1234_5678);
    wr(8'h08, 32'hFFFF_FFFF);
    rd_chk(8'h08, 32'h0000_0ABC, "R11 own position");
    rd_chk(8'h00, 32'h1234_5678, "R11 write to position changes nothing");
    rd_chk(8'h0C, 32'h0, "R11 doorbell reads zero");
    rd_chk(8'h40, 32'h0, "R11 unmapped offset reads zero");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule